// File: doc/BRIEF.md
# Flash Page Access Permission Checker

This block judges every flash request before it reaches the array. A request names a page, an operation (read, program, page erase or bank erase), the partition it targets (data or info) and the path it came from (the software controller or the hardware host read port). The block holds a set of configurable page windows. Each window has a first page, a length in pages, an enable and its own read, program and erase permits. The lowest-numbered enabled window that covers the page decides which permits apply. If no window covers the page, a default set of permits applies.

A bank erase ignores the windows and is allowed only by a separate per-bank erase enable. The host read port may never reach the info partition. Operation codes outside the defined set are always rejected and raise a recoverable alert. The decision is registered. Every denied request, whatever its cause, sets a permission-error strobe that feeds the error code register. The window settings come in on plain input ports.

Top module: `flash_perm_chk`

## Requirements
- R1: A window covers page p when it is enabled and base <= p < base+count, computed without overflow. A window with count 0 or with its enable low covers nothing.
- R2: When two or more enabled windows cover the page, only the permits of the window with the lowest index are used.
- R3: When no enabled window covers the page, the default read, program and erase permits are used.
- R4: Op codes are 0 read, 1 program, 2 page erase and 3 bank erase. Read needs the read permit, program needs the program permit and page erase needs the erase permit.
- R5: A bank erase (op 3) is allowed only when bit b of the bank erase enable is set, where b is the page's bank (page / PAGES_PER_BANK). Window permits have no effect on it.
- R6: A request from the host read port (src=1) that targets the info partition (part=1) is denied. A host request with any op other than read is also denied.
- R7: Op codes 4 to 7 are denied, and alert_o pulses for one cycle.
- R8: The results appear on the clock edge that follows the valid request: grant_o and deny_o are exclusive, exactly one of them is high, and mp_err_o equals deny_o. With no valid request, all outputs are low on the next cycle.
- R9: After reset, grant_o, deny_o, mp_err_o and alert_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_page_i | input | PAGE_W | Target page |
| req_op_i | input | 3 | Operation code |
| req_part_i | input | 1 | 0 data, 1 info partition |
| req_src_i | input | 1 | 0 controller, 1 host read port |
| win_en_i | input | NWIN | Window enables |
| win_base_i | input | NWIN*PAGE_W | Window first pages, packed by index |
| win_cnt_i | input | NWIN*PAGE_W | Window lengths in pages |
| win_rd_i | input | NWIN | Window read permits |
| win_pg_i | input | NWIN | Window program permits |
| win_er_i | input | NWIN | Window erase permits |
| dflt_perm_i | input | 3 | Default permits {erase, program, read} |
| bank_er_en_i | input | NBANK | Per-bank erase enable |
| grant_o | output | 1 | Request allowed |
| deny_o | output | 1 | Request denied |
| mp_err_o | output | 1 | Permission error strobe |
| alert_o | output | 1 | Invalid-op recoverable alert |

## Verification
On every cycle the assertions check that grant and deny are exclusive, that a registered result follows each valid request, that the outputs stay quiet when no request came, that a host request to the info partition is denied, that an invalid op raises the alert, and that the error strobe matches the deny. Only the bench can show that the window priority, the boundary pages and the default and bank-erase rules reach the right decision. It does this by comparing random window sets, some of them overlapping, against a model that scans the windows in index order.

// File: rtl/flash_perm_pkg.sv
package flash_perm_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_PROG  = 3'd1,
        OP_PERA  = 3'd2,
        OP_BERA  = 3'd3
    } op_e;

    typedef struct packed {
        logic rd;
        logic pg;
        logic er;
    } perm_t;

    typedef struct packed {
        logic grant;
        logic deny;
        logic mp_err;
        logic alert;
    } decide_t;
endpackage

// File: rtl/flash_win_match.sv
module flash_win_match #(
    parameter int PAGE_W = 8
) (
    input  logic              en_i,
    input  logic [PAGE_W-1:0] base_i,
    input  logic [PAGE_W-1:0] cnt_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              hit_o
);
    logic [PAGE_W:0] end_w;

    always_comb begin
        end_w = {1'b0, base_i} + {1'b0, cnt_i};
        hit_o = en_i && (page_i >= base_i) && ({1'b0, page_i} < end_w);
    end
endmodule

// File: rtl/flash_win_prio.sv
module flash_win_prio #(
    parameter int NWIN = 8
) (
    input  logic                 [NWIN-1:0] hit_i,
    input  flash_perm_pkg::perm_t [NWIN-1:0] perm_i,
    input  flash_perm_pkg::perm_t            dflt_i,
    output flash_perm_pkg::perm_t            perm_o
);
    always_comb begin
        perm_o = dflt_i;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit_i[i]) perm_o = perm_i[i];
        end
    end
endmodule

// File: rtl/flash_perm_chk.sv
module flash_perm_chk #(
    parameter int PAGE_W         = 8,
    parameter int NWIN           = 8,
    parameter int NBANK          = 2,
    parameter int PAGES_PER_BANK = 128
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   req_valid_i,
    input  logic [PAGE_W-1:0]      req_page_i,
    input  logic [2:0]             req_op_i,
    input  logic                   req_part_i,
    input  logic                   req_src_i,
    input  logic [NWIN-1:0]        win_en_i,
    input  logic [NWIN*PAGE_W-1:0] win_base_i,
    input  logic [NWIN*PAGE_W-1:0] win_cnt_i,
    input  logic [NWIN-1:0]        win_rd_i,
    input  logic [NWIN-1:0]        win_pg_i,
    input  logic [NWIN-1:0]        win_er_i,
    input  logic [2:0]             dflt_perm_i,
    input  logic [NBANK-1:0]       bank_er_en_i,
    output logic                   grant_o,
    output logic                   deny_o,
    output logic                   mp_err_o,
    output logic                   alert_o
);
    import flash_perm_pkg::*;

    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic  [NWIN-1:0] hit;
    perm_t [NWIN-1:0] win_perm;
    perm_t            dflt;
    perm_t            sel;
    decide_t          res_d, res_q;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        flash_win_match #(.PAGE_W(PAGE_W)) u_match (
            .en_i   (win_en_i[g]),
            .base_i (win_base_i[g*PAGE_W +: PAGE_W]),
            .cnt_i  (win_cnt_i[g*PAGE_W +: PAGE_W]),
            .page_i (req_page_i),
            .hit_o  (hit[g])
        );
        assign win_perm[g] = '{rd: win_rd_i[g], pg: win_pg_i[g], er: win_er_i[g]};
    end

    assign dflt = '{rd: dflt_perm_i[0], pg: dflt_perm_i[1], er: dflt_perm_i[2]};

    flash_win_prio #(.NWIN(NWIN)) u_prio (
        .hit_i  (hit),
        .perm_i (win_perm),
        .dflt_i (dflt),
        .perm_o (sel)
    );

    logic [BANK_W-1:0] bank;
    logic              bank_ok;
    logic [31:0]       bank_full;

    always_comb begin
        bank_full = 32'(req_page_i) / 32'(PAGES_PER_BANK);
        bank      = bank_full[BANK_W-1:0];
        bank_ok   = (bank_full < 32'(NBANK)) && bank_er_en_i[bank];
    end

    always_comb begin
        logic ok;
        logic bad_op;
        res_d  = '0;
        ok     = 1'b0;
        bad_op = 1'b0;
        case (req_op_i)
            OP_READ: ok = sel.rd;
            OP_PROG: ok = sel.pg;
            OP_PERA: ok = sel.er;
            OP_BERA: ok = bank_ok;
            default: bad_op = 1'b1;
        endcase
        if (req_src_i && (req_part_i || req_op_i != OP_READ)) ok = 1'b0;
        if (req_valid_i) begin
            res_d.grant  = ok && !bad_op;
            res_d.deny   = !(ok && !bad_op);
            res_d.mp_err = !(ok && !bad_op);
            res_d.alert  = bad_op;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign grant_o  = res_q.grant;
    assign deny_o   = res_q.deny;
    assign mp_err_o = res_q.mp_err;
    assign alert_o  = res_q.alert;
endmodule

// File: rtl/flash_perm_chk_sva.sv
module flash_perm_chk_sva (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_valid_i,
    input logic [2:0] req_op_i,
    input logic       req_part_i,
    input logic       req_src_i,
    input logic       grant_o,
    input logic       deny_o,
    input logic       mp_err_o,
    input logic       alert_o
);
    // R8
    excl_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(grant_o && deny_o));
    // R8
    answer_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> (grant_o || deny_o));
    // R8
    quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !(grant_o || deny_o || alert_o || mp_err_o));
    // R8
    err_tracks_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mp_err_o == deny_o);
    // R6
    host_info_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_src_i && req_part_i) |=> deny_o);
    // R7
    bad_op_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_op_i[2]) |=> (alert_o && deny_o));
endmodule

bind flash_perm_chk flash_perm_chk_sva u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_part_i  (req_part_i),
    .req_src_i   (req_src_i),
    .grant_o     (grant_o),
    .deny_o      (deny_o),
    .mp_err_o    (mp_err_o),
    .alert_o     (alert_o)
);

// File: tb/flash_perm_chk_bench.sv
module flash_perm_chk_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE_W = 8;
    localparam int NWIN = 8;
    localparam int NBANK = 2;
    localparam int PPB = 128;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [PAGE_W-1:0] req_page = 0;
    logic [2:0] req_op = 0;
    logic req_part = 0, req_src = 0;
    logic [NWIN-1:0] win_en = 0, win_rd = 0, win_pg = 0, win_er = 0;
    logic [NWIN*PAGE_W-1:0] win_base = 0, win_cnt = 0;
    logic [2:0] dflt = 0;
    logic [NBANK-1:0] bank_en = 0;
    logic grant, deny, mp_err, alert;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_perm_chk #(.PAGE_W(PAGE_W), .NWIN(NWIN), .NBANK(NBANK), .PAGES_PER_BANK(PPB)) u_flash_perm_chk (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_page_i(req_page),
        .req_op_i(req_op), .req_part_i(req_part), .req_src_i(req_src),
        .win_en_i(win_en), .win_base_i(win_base), .win_cnt_i(win_cnt),
        .win_rd_i(win_rd), .win_pg_i(win_pg), .win_er_i(win_er),
        .dflt_perm_i(dflt), .bank_er_en_i(bank_en),
        .grant_o(grant), .deny_o(deny), .mp_err_o(mp_err), .alert_o(alert));

    // stimulus vectors: {page, op, part, src, expected grant}
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {8'd10, 3'd0, 1'b0, 1'b0, 1'b1}, // R1 base page of window 0
        {8'd19, 3'd0, 1'b0, 1'b0, 1'b1}, // R1 last page inside
        {8'd20, 3'd1, 1'b0, 1'b0, 1'b1}, // R1 first page past w0 -> w1 program ok
        {8'd15, 3'd1, 1'b0, 1'b0, 1'b0}, // R2 overlap: w0 wins, no program
        {8'd15, 3'd2, 1'b0, 1'b0, 1'b0}, // R4 erase denied by w0
        {8'd25, 3'd2, 1'b0, 1'b0, 1'b1}, // R4 erase allowed by w1
        {8'd100,3'd0, 1'b0, 1'b0, 1'b0}, // R3 default: no read
        {8'd100,3'd1, 1'b0, 1'b0, 1'b1}, // R3 default: program
        {8'd5,  3'd3, 1'b0, 1'b0, 1'b1}, // R5 bank 0 enabled
        {8'd200,3'd3, 1'b0, 1'b0, 1'b0}, // R5 bank 1 disabled
        {8'd12, 3'd0, 1'b1, 1'b1, 1'b0}, // R6 host info read
        {8'd12, 3'd5, 1'b0, 1'b0, 1'b0}  // R7 invalid op
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] pg, input logic [2:0] op, input logic pt, input logic sr);
        @(negedge clk);
        req_valid = 1; req_page = pg; req_op = op; req_part = pt; req_src = sr;
        @(negedge clk);
        req_valid = 0;
    endtask

    function automatic logic model(input logic [7:0] pg, input logic [2:0] op, input logic pt, input logic sr);
        logic [2:0] p;
        logic found;
        p = dflt; found = 0;
        for (int i = 0; i < NWIN; i++) begin
            int b, c;
            b = win_base[i*PAGE_W +: PAGE_W];
            c = win_cnt[i*PAGE_W +: PAGE_W];
            if (!found && win_en[i] && int'(pg) >= b && int'(pg) < b + c) begin
                p = {win_er[i], win_pg[i], win_rd[i]};
                found = 1;
            end
        end
        if (op > 3) return 0;
        if (sr && (pt || op != 0)) return 0;
        case (op)
            3'd0: return p[0];
            3'd1: return p[1];
            3'd2: return p[2];
            default: return bank_en[int'(pg) / PPB];
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD*5000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R9 reset state
        chk("R9 grant", grant, 0); chk("R9 deny", deny, 0);
        chk("R9 mp_err", mp_err, 0); chk("R9 alert", alert, 0);
        rst_n = 1;
        // w0: pages 10..19 read only; w1: 15..34 read/prog/erase
        win_en = 8'b0000_0011;
        win_base[0 +: 8] = 8'd10; win_cnt[0 +: 8] = 8'd10;
        win_base[8 +: 8] = 8'd15; win_cnt[8 +: 8] = 8'd20;
        win_rd = 8'b11; win_pg = 8'b10; win_er = 8'b10;
        dflt = 3'b010; bank_en = 2'b01;
        for (int v = 0; v < NV; v++) begin
            issue(VEC[v][13:6], VEC[v][5:3], VEC[v][2], VEC[v][1]);
            chk($sformatf("R1-vec%0d grant", v), grant, VEC[v][0]);
            chk($sformatf("R8 vec%0d deny", v), deny, !VEC[v][0]);
            chk("R8 mp_err", mp_err, !VEC[v][0]);
        end
        // R7 alert and R8 idle
        issue(8'd0, 3'd7, 0, 0);
        chk("R7 alert", alert, 1);
        @(negedge clk);
        chk("R8 idle grant", grant, 0); chk("R8 idle alert", alert, 0);
        // R6 host program on data denied, host data read allowed
        issue(8'd12, 3'd1, 0, 1); chk("R6 host prog", grant, 0);
        issue(8'd12, 3'd0, 0, 1); chk("R6 host data read", grant, 1);
        // R1 disabled window and zero count
        win_en = 8'b10; issue(8'd12, 3'd0, 0, 0); chk("R1 disabled w0 -> w0 skipped w1? page12 default", grant, 0);
        win_en = 8'b11; win_cnt[0 +: 8] = 0; issue(8'd10, 3'd0, 0, 0); chk("R1 zero count", grant, 0);
        // R1 overflow window at top
        win_base[16 +: 8] = 8'd250; win_cnt[16 +: 8] = 8'd20; win_en[2] = 1; win_rd[2] = 1;
        issue(8'd255, 3'd0, 0, 0); chk("R1 top wrap", grant, 1);
        issue(8'd3, 3'd0, 0, 0); chk("R1 no wrap", grant, 0);
        // R2 random regions against model
        for (int t = 0; t < 300; t++) begin
            logic [7:0] pg; logic [2:0] op; logic pt, sr, e;
            if (t % 20 == 0) begin
                win_en = NWIN'($urandom); win_rd = NWIN'($urandom);
                win_pg = NWIN'($urandom); win_er = NWIN'($urandom);
                for (int i = 0; i < NWIN; i++) begin
                    win_base[i*PAGE_W +: PAGE_W] = 8'($urandom);
                    win_cnt[i*PAGE_W +: PAGE_W] = 8'($urandom_range(0, 80));
                end
                dflt = 3'($urandom); bank_en = NBANK'($urandom);
            end
            pg = 8'($urandom); op = 3'($urandom_range(0, 4));
            pt = 1'($urandom); sr = ($urandom_range(0, 3) == 0);
            e = model(pg, op, pt, sr);
            issue(pg, op, pt, sr);
            chk($sformatf("R2 rand pg=%0d op=%0d", pg, op), grant, e);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule